// File: doc/BRIEF.md
# Conversion Start Scheduler

This block sits between the trigger sources of a chip and a single analog-to-digital conversion engine. It serves nineteen sample slots. Each slot picks one start source from a coded list: none, an external start pin, or one of eighteen on-chip pulse lines. The pulse lines carry interrupt-line end-of-conversion pulses, timer overflows and PWM trigger events. A slot can also hold off its hardware start by a programmable delay, counted in a divided copy of the block clock. Software can mark any set of slots pending with one mask write, and it can withdraw pending slots by writing ones to a cancel mask.

Pending slots are handed to the converter one at a time, lowest slot number first. A slot's pending bit stays set until the converter signals that the slot's conversion has finished. A start that reaches a slot which is already pending, or which is already counting its delay, is dropped. The drop raises a sticky per-slot overrun flag, which software clears by writing ones.

The converter side is a valid/ready offer followed by a one-cycle done pulse. The offer is only made while no conversion is running. The converter takes the slot and channel shown in the cycle where `conv_vld` and `conv_rdy` are both high. Before that handshake the offer is not held stable. It may move to a lower slot that has just become pending, and it may drop when its slot is cancelled. The converter may hold `conv_rdy` low for as long as it likes, and nothing is lost while it does. Only one conversion is ever in flight, and `conv_done` is ignored while idle.

Top module: `conv_trig_sched`

## Requirements
- R1: A slot's 5-bit source code selects its hardware start. Code 0 selects no hardware source. Code 1 selects the external pin. Code k, for k from 2 to 19, selects `hw_trig[k-2]`. Codes 20 to 31 never start the slot.
- R2: With the pin selected, the slot's rise enable admits rising pin edges and its fall enable admits falling pin edges. Either edge starts the slot when both enables are set. The pin passes through a two-flop synchronizer, so with a zero delay the pending bit is seen after the third rising clock edge following the pin change.
- R3: When a slot's delay count is 0, a hardware start sampled at a clock edge sets pending at that same edge. When the count is D > 0, pending is set after D ticks of the delay clock. The delay clock ticks every 1, 2, 4 or 16 clock cycles for divider codes 0, 1, 2 and 3, taken from a free-running 4-bit prescaler that reset clears.
- R4: A software start marks pending every slot whose bit n is set in `sw_start_mask`, whatever the slot's source code.
- R5: A pending bit stays 1 until the done pulse of that slot's conversion, and then clears. A cancel write clears every masked pending bit at once and stops any delay that is running in those slots.
- R6: Any start that reaches a slot whose pending bit is 1, or whose delay is running, is dropped and sets that slot's overrun flag. The flag stays set until a clear write has a 1 in its bit. If a set and a clear land in the same cycle, the set wins. `ovf_any` is 1 while any overrun flag is 1.
- R7: `conv_vld` is high only while no conversion is running and some slot is pending. It offers the lowest-numbered pending slot on `conv_slot`, with that slot's channel on `conv_chan`.
- R8: `busy` rises at the edge where the offer is accepted and falls at the edge where `conv_done` arrives. A further offer can appear right after that edge.
- R9: A start that reaches a slot in the same cycle as the done pulse for that slot is accepted. The slot stays pending and no overrun is recorded.
- R10: If the slot in flight is cancelled, its conversion still runs to its done pulse. That done pulse does not clear a newer start of the same slot that arrived while the conversion was running.
- R11: After reset, no slot is pending, no overrun flag is set, `busy` and `conv_vld` are low, and no delay is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block and converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_start_vld | input | 1 | Software start write strobe |
| sw_start_mask | input | 19 | Slots to mark pending, bit n = slot n |
| cancel_vld | input | 1 | Cancel write strobe |
| cancel_mask | input | 19 | Pending slots to withdraw |
| ovf_clr_vld | input | 1 | Overrun clear write strobe |
| ovf_clr_mask | input | 19 | Overrun flags to clear |
| slot_src_sel | input | 95 | Per-slot 5-bit source code, slot n at [5n+:5] |
| slot_rise_en | input | 19 | Per-slot rising pin edge enable |
| slot_fall_en | input | 19 | Per-slot falling pin edge enable |
| slot_div | input | 38 | Per-slot 2-bit delay divider code, slot n at [2n+:2] |
| slot_dly | input | 152 | Per-slot 8-bit delay count, slot n at [8n+:8] |
| slot_chan | input | 95 | Per-slot 5-bit converter channel, slot n at [5n+:5] |
| ext_start_pin | input | 1 | Asynchronous external start pin |
| hw_trig | input | 18 | On-chip start pulses, one clock wide |
| conv_vld | output | 1 | Conversion offer valid |
| conv_rdy | input | 1 | Converter accepts the offer |
| conv_slot | output | 5 | Offered slot number |
| conv_chan | output | 5 | Channel of the offered slot |
| conv_done | input | 1 | End-of-conversion pulse |
| pending | output | 19 | Per-slot pending bits |
| ovf_flags | output | 19 | Per-slot sticky overrun flags |
| ovf_any | output | 1 | OR of all overrun flags |
| busy | output | 1 | A conversion is in flight |

## Verification
Two collisions on the same slot are worth provoking: a new start against the done pulse that frees the slot, and a new start against the cancel that empties it. The bench drives a software start in the exact cycle of `conv_done` and expects the slot to stay pending with no overrun. It also cancels an in-flight slot, starts it again while busy, and expects the later done pulse to leave the new request in place. Overrun set against overrun clear in one cycle is driven too, and the flag must survive.

// File: rtl/ts_pkg.sv
package ts_pkg;

  typedef enum logic [1:0] {
    DIV_BY1  = 2'd0,
    DIV_BY2  = 2'd1,
    DIV_BY4  = 2'd2,
    DIV_BY16 = 2'd3
  } div_code_e;

  localparam int PRESC_W  = 4;
  localparam int SRC_NONE = 0;
  localparam int SRC_PIN  = 1;
  localparam int SRC_HW0  = 2;

  // One tick of the divided delay clock, taken from a shared prescaler.
  function automatic logic div_tick(input logic [1:0] code, input logic [PRESC_W-1:0] presc);
    case (div_code_e'(code))
      DIV_BY1:  return 1'b1;
      DIV_BY2:  return presc[0];
      DIV_BY4:  return &presc[1:0];
      default:  return &presc;
    endcase
  endfunction

endpackage

// File: rtl/ts_pin_edge.sv
module ts_pin_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic pin_rise,
  output logic pin_fall
);
  logic [1:0] sync_q;
  logic       last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
      last_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], pin};
      last_q <= sync_q[1];
    end
  end

  assign pin_rise = sync_q[1] & ~last_q;
  assign pin_fall = ~sync_q[1] & last_q;
endmodule

// File: rtl/ts_slot_trig.sv
module ts_slot_trig
  import ts_pkg::*;
#(
  parameter int NUM_HW = 18,
  parameter int DLY_W  = 8,
  parameter int SRC_W  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SRC_W-1:0]   src_sel,
  input  logic               rise_en,
  input  logic               fall_en,
  input  logic [1:0]         div_code,
  input  logic [DLY_W-1:0]   dly,
  input  logic               pin_rise,
  input  logic               pin_fall,
  input  logic [NUM_HW-1:0]  hw_trig,
  input  logic [PRESC_W-1:0] presc,
  input  logic               slot_taken,
  input  logic               cancel,
  output logic               fire,
  output logic               drop,
  output logic               dly_run
);
  logic             hit;
  logic             tick;
  logic             zero_dly;
  logic             start_dly;
  logic             act_q;
  logic [DLY_W-1:0] cnt_q;

  always_comb begin
    hit = 1'b0;
    if (src_sel == SRC_W'(SRC_PIN)) begin
      hit = (rise_en & pin_rise) | (fall_en & pin_fall);
    end
    for (int k = 0; k < NUM_HW; k++) begin
      if (src_sel == SRC_W'(k + SRC_HW0)) hit = hit | hw_trig[k];
    end
  end

  assign tick      = div_tick(div_code, presc);
  assign zero_dly  = (dly == '0);
  assign drop      = hit & ~zero_dly & ((act_q & ~cancel) | slot_taken);
  assign start_dly = hit & ~zero_dly & ~drop;
  assign fire      = (hit & zero_dly) |
                     (act_q & tick & (cnt_q == DLY_W'(1)) & ~cancel);
  assign dly_run   = act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_dly) begin
      act_q <= 1'b1;
      cnt_q <= dly;
    end else if (cancel) begin
      act_q <= 1'b0;
    end else if (act_q && tick) begin
      if (cnt_q == DLY_W'(1)) act_q <= 1'b0;
      cnt_q <= cnt_q - DLY_W'(1);
    end
  end
endmodule

// File: rtl/ts_arbiter.sv
module ts_arbiter #(
  parameter int NUM_SLOTS = 19,
  parameter int SLOT_W    = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] pend,
  input  logic [NUM_SLOTS-1:0] cancel_eff,
  input  logic                 conv_rdy,
  input  logic                 conv_done,
  output logic                 conv_vld,
  output logic [SLOT_W-1:0]    conv_slot,
  output logic                 busy,
  output logic [NUM_SLOTS-1:0] done_clr
);
  logic [SLOT_W-1:0] pick;
  logic [SLOT_W-1:0] fly_q;
  logic              busy_q;
  logic              orphan_q;
  logic              accept;

  // Scan from the top down so the lowest pending slot wins.
  always_comb begin
    pick = '0;
    for (int k = NUM_SLOTS - 1; k >= 0; k--) begin
      if (pend[k]) pick = SLOT_W'(k);
    end
  end

  assign conv_vld  = ~busy_q & (|pend);
  assign conv_slot = pick;
  assign accept    = conv_vld & conv_rdy;
  assign busy      = busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      fly_q    <= '0;
      orphan_q <= 1'b0;
    end else if (accept) begin
      busy_q   <= 1'b1;
      fly_q    <= pick;
      orphan_q <= cancel_eff[pick];
    end else if (busy_q) begin
      if (conv_done) begin
        busy_q   <= 1'b0;
        orphan_q <= 1'b0;
      end else if (cancel_eff[fly_q]) begin
        orphan_q <= 1'b1;
      end
    end
  end

  always_comb begin
    done_clr = '0;
    if (busy_q && conv_done && !orphan_q) done_clr[fly_q] = 1'b1;
  end
endmodule

// File: rtl/conv_trig_sched.sv
module conv_trig_sched
  import ts_pkg::*;
#(
  parameter int  NUM_SLOTS = 19,
  parameter int  NUM_HW    = 18,
  parameter int  DLY_W     = 8,
  parameter int  CH_W      = 5,
  localparam int SRC_W     = $clog2(NUM_HW + SRC_HW0),
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sw_start_vld,
  input  logic [NUM_SLOTS-1:0]       sw_start_mask,
  input  logic                       cancel_vld,
  input  logic [NUM_SLOTS-1:0]       cancel_mask,
  input  logic                       ovf_clr_vld,
  input  logic [NUM_SLOTS-1:0]       ovf_clr_mask,
  input  logic [NUM_SLOTS*SRC_W-1:0] slot_src_sel,
  input  logic [NUM_SLOTS-1:0]       slot_rise_en,
  input  logic [NUM_SLOTS-1:0]       slot_fall_en,
  input  logic [NUM_SLOTS*2-1:0]     slot_div,
  input  logic [NUM_SLOTS*DLY_W-1:0] slot_dly,
  input  logic [NUM_SLOTS*CH_W-1:0]  slot_chan,
  input  logic                       ext_start_pin,
  input  logic [NUM_HW-1:0]          hw_trig,
  output logic                       conv_vld,
  input  logic                       conv_rdy,
  output logic [SLOT_W-1:0]          conv_slot,
  output logic [CH_W-1:0]            conv_chan,
  input  logic                       conv_done,
  output logic [NUM_SLOTS-1:0]       pending,
  output logic [NUM_SLOTS-1:0]       ovf_flags,
  output logic                       ovf_any,
  output logic                       busy
);
  logic [PRESC_W-1:0]   presc_q;
  logic                 pin_rise;
  logic                 pin_fall;
  logic [NUM_SLOTS-1:0] pend_q;
  logic [NUM_SLOTS-1:0] ovf_q;
  logic [NUM_SLOTS-1:0] sw_eff;
  logic [NUM_SLOTS-1:0] cancel_eff;
  logic [NUM_SLOTS-1:0] clr_eff;
  logic [NUM_SLOTS-1:0] done_clr;
  logic [NUM_SLOTS-1:0] held;
  logic [NUM_SLOTS-1:0] fire;
  logic [NUM_SLOTS-1:0] drop;
  logic [NUM_SLOTS-1:0] dly_run;
  logic [NUM_SLOTS-1:0] req;
  logic [NUM_SLOTS-1:0] ovf_set;

  assign sw_eff     = sw_start_vld ? sw_start_mask : '0;
  assign cancel_eff = cancel_vld   ? cancel_mask   : '0;
  assign clr_eff    = ovf_clr_vld  ? ovf_clr_mask  : '0;

  // Requests that remain after this cycle's cancels and completions.
  assign held    = pend_q & ~cancel_eff & ~done_clr;
  assign req     = sw_eff | fire;
  assign ovf_set = (req & held) | drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= '0;
      pend_q  <= '0;
      ovf_q   <= '0;
    end else begin
      presc_q <= presc_q + PRESC_W'(1);
      pend_q  <= held | req;
      ovf_q   <= (ovf_q & ~clr_eff) | ovf_set;
    end
  end

  ts_pin_edge u_pin (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin      (ext_start_pin),
    .pin_rise (pin_rise),
    .pin_fall (pin_fall)
  );

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    ts_slot_trig #(
      .NUM_HW (NUM_HW),
      .DLY_W  (DLY_W),
      .SRC_W  (SRC_W)
    ) u_trig (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_sel    (slot_src_sel[s*SRC_W +: SRC_W]),
      .rise_en    (slot_rise_en[s]),
      .fall_en    (slot_fall_en[s]),
      .div_code   (slot_div[s*2 +: 2]),
      .dly        (slot_dly[s*DLY_W +: DLY_W]),
      .pin_rise   (pin_rise),
      .pin_fall   (pin_fall),
      .hw_trig    (hw_trig),
      .presc      (presc_q),
      .slot_taken (held[s]),
      .cancel     (cancel_eff[s]),
      .fire       (fire[s]),
      .drop       (drop[s]),
      .dly_run    (dly_run[s])
    );
  end

  ts_arbiter #(
    .NUM_SLOTS (NUM_SLOTS),
    .SLOT_W    (SLOT_W)
  ) u_arb (
    .clk        (clk),
    .rst_n      (rst_n),
    .pend       (pend_q),
    .cancel_eff (cancel_eff),
    .conv_rdy   (conv_rdy),
    .conv_done  (conv_done),
    .conv_vld   (conv_vld),
    .conv_slot  (conv_slot),
    .busy       (busy),
    .done_clr   (done_clr)
  );

  always_comb begin
    conv_chan = '0;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (conv_slot == SLOT_W'(k)) conv_chan = slot_chan[k*CH_W +: CH_W];
    end
  end

  assign pending   = pend_q;
  assign ovf_flags = ovf_q;
  assign ovf_any   = |ovf_q;
endmodule

// File: rtl/ts_sched_chk.sv
module ts_sched_chk #(
  parameter int NUM_SLOTS = 19,
  parameter int SLOT_W    = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sw_start_vld,
  input logic [NUM_SLOTS-1:0] sw_start_mask,
  input logic                 ovf_clr_vld,
  input logic [NUM_SLOTS-1:0] ovf_clr_mask,
  input logic                 conv_vld,
  input logic                 conv_rdy,
  input logic [SLOT_W-1:0]    conv_slot,
  input logic                 conv_done,
  input logic [NUM_SLOTS-1:0] pending,
  input logic [NUM_SLOTS-1:0] ovf_flags,
  input logic                 busy
);
  logic [NUM_SLOTS-1:0] keep_ovf;
  logic [NUM_SLOTS-1:0] below;

  assign keep_ovf = ovf_flags & ~(ovf_clr_vld ? ovf_clr_mask : '0);
  assign below    = (NUM_SLOTS'(1) << conv_slot) - NUM_SLOTS'(1);

  p_offer_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_vld |-> !busy);

  p_lowest_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conv_vld |-> (pending[conv_slot] && ((pending & below) == '0)));

  p_busy_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (conv_vld && conv_rdy) |=> busy);

  p_free_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && conv_done) |=> !busy);

  p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((ovf_flags & $past(keep_ovf)) == $past(keep_ovf)));

  p_sw_marks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sw_start_vld |=> ((pending & $past(sw_start_mask)) == $past(sw_start_mask)));
endmodule

bind conv_trig_sched ts_sched_chk #(
  .NUM_SLOTS (NUM_SLOTS),
  .SLOT_W    (SLOT_W)
) u_sched_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sw_start_vld  (sw_start_vld),
  .sw_start_mask (sw_start_mask),
  .ovf_clr_vld   (ovf_clr_vld),
  .ovf_clr_mask  (ovf_clr_mask),
  .conv_vld      (conv_vld),
  .conv_rdy      (conv_rdy),
  .conv_slot     (conv_slot),
  .conv_done     (conv_done),
  .pending       (pending),
  .ovf_flags     (ovf_flags),
  .busy          (busy)
);

// File: tb/tb_conv_trig_sched.sv
module tb_conv_trig_sched;
  localparam int CLK_PERIOD = 10;
  localparam int NS  = 19;
  localparam int NHW = 18;
  localparam int DW  = 8;
  localparam int CW  = 5;
  localparam int SW  = 5;
  localparam int SLW = 5;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sw_start_vld = 1'b0;
  logic [NS-1:0] sw_start_mask = '0;
  logic cancel_vld = 1'b0;
  logic [NS-1:0] cancel_mask = '0;
  logic ovf_clr_vld = 1'b0;
  logic [NS-1:0] ovf_clr_mask = '0;
  logic [NS*SW-1:0] slot_src_sel;
  logic [NS-1:0] slot_rise_en;
  logic [NS-1:0] slot_fall_en;
  logic [NS*2-1:0] slot_div;
  logic [NS*DW-1:0] slot_dly;
  logic [NS*CW-1:0] slot_chan;
  logic ext_start_pin = 1'b0;
  logic [NHW-1:0] hw_trig = '0;
  logic conv_vld;
  logic conv_rdy = 1'b0;
  logic [SLW-1:0] conv_slot;
  logic [CW-1:0] conv_chan;
  logic conv_done = 1'b0;
  logic [NS-1:0] pending;
  logic [NS-1:0] ovf_flags;
  logic ovf_any;
  logic busy;

  logic [SW-1:0] c_src [NS];
  logic          c_rise [NS];
  logic          c_fall [NS];
  logic [1:0]    c_div [NS];
  logic [DW-1:0] c_dly [NS];

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int k = 0; k < NS; k++) begin
      slot_src_sel[k*SW +: SW] = c_src[k];
      slot_rise_en[k]          = c_rise[k];
      slot_fall_en[k]          = c_fall[k];
      slot_div[k*2 +: 2]       = c_div[k];
      slot_dly[k*DW +: DW]     = c_dly[k];
      slot_chan[k*CW +: CW]    = CW'((k * 3 + 1) % 32);
    end
  end

  conv_trig_sched dut (
    .clk (clk), .rst_n (rst_n),
    .sw_start_vld (sw_start_vld), .sw_start_mask (sw_start_mask),
    .cancel_vld (cancel_vld), .cancel_mask (cancel_mask),
    .ovf_clr_vld (ovf_clr_vld), .ovf_clr_mask (ovf_clr_mask),
    .slot_src_sel (slot_src_sel), .slot_rise_en (slot_rise_en),
    .slot_fall_en (slot_fall_en), .slot_div (slot_div),
    .slot_dly (slot_dly), .slot_chan (slot_chan),
    .ext_start_pin (ext_start_pin), .hw_trig (hw_trig),
    .conv_vld (conv_vld), .conv_rdy (conv_rdy),
    .conv_slot (conv_slot), .conv_chan (conv_chan),
    .conv_done (conv_done), .pending (pending),
    .ovf_flags (ovf_flags), .ovf_any (ovf_any), .busy (busy)
  );

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    cancel_vld = 1'b1; cancel_mask = '1;
    ovf_clr_vld = 1'b1; ovf_clr_mask = '1;
    step(1);
    cancel_vld = 1'b0; cancel_mask = '0;
    ovf_clr_vld = 1'b0; ovf_clr_mask = '0;
  endtask

  task automatic sw_start(logic [NS-1:0] m);
    sw_start_vld = 1'b1; sw_start_mask = m;
    step(1);
    sw_start_vld = 1'b0; sw_start_mask = '0;
  endtask

  // Acts as the converter for one conversion of slot s.
  task automatic serve(int s, bit restart_at_done, bit cancel_restart, logic [NS-1:0] inject);
    check("R7 offer valid", 32'(conv_vld), 32'd1);
    check("R7 offered slot", 32'(conv_slot), 32'(s));
    check("R7 offered channel", 32'(conv_chan), 32'((s * 3 + 1) % 32));
    conv_rdy = 1'b1;
    step(1);
    conv_rdy = 1'b0;
    check("R8 busy after accept", 32'(busy), 32'd1);
    check("R7 no offer while busy", 32'(conv_vld), 32'd0);
    if (inject != '0) sw_start(inject);
    if (cancel_restart) begin
      cancel_vld = 1'b1; cancel_mask = NS'(1) << s;
      step(1);
      cancel_vld = 1'b0; cancel_mask = '0;
      check("R10 in-flight slot cancelled", 32'(pending[s]), 32'd0);
      check("R10 still busy", 32'(busy), 32'd1);
      sw_start(NS'(1) << s);
      check("R10 restart pending", 32'(pending[s]), 32'd1);
    end
    step(1);
    check("R8 busy held until done", 32'(busy), 32'd1);
    conv_done = 1'b1;
    if (restart_at_done) begin
      sw_start_vld = 1'b1; sw_start_mask = NS'(1) << s;
    end
    step(1);
    conv_done = 1'b0;
    sw_start_vld = 1'b0; sw_start_mask = '0;
    check("R8 busy falls at done", 32'(busy), 32'd0);
  endtask

  initial begin
    for (int k = 0; k < NS; k++) begin
      c_src[k] = '0; c_rise[k] = 1'b0; c_fall[k] = 1'b0;
      c_div[k] = 2'd0; c_dly[k] = '0;
    end
    step(3);
    rst_n = 1'b1;
    step(1);

    // R11: reset state
    check("R11 pending", 32'(pending), 32'd0);
    check("R11 overrun", 32'(ovf_flags), 32'd0);
    check("R11 ovf_any", 32'(ovf_any), 32'd0);
    check("R11 busy", 32'(busy), 32'd0);
    check("R11 conv_vld", 32'(conv_vld), 32'd0);

    // R1: every source code against every pulse line, zero delay (R3)
    for (int c = 0; c < 32; c++) begin
      c_src[0] = SW'(c);
      for (int b = 0; b < NHW; b++) begin
        hw_trig = NHW'(1) << b;
        step(1);
        hw_trig = '0;
        check("R1 source decode", 32'(pending),
              (c >= 2 && c <= 19 && (c - 2) == b) ? 32'd1 : 32'd0);
        clear_all();
      end
    end

    // R2: pin edges under all enable combinations
    c_src[0] = SW'(1);
    for (int e = 0; e < 4; e++) begin
      c_rise[0] = e[0]; c_fall[0] = e[1];
      ext_start_pin = 1'b1;
      step(2);
      check("R2 rise not yet seen", 32'(pending[0]), 32'd0);
      step(1);
      check("R2 rising edge", 32'(pending[0]), 32'(e[0]));
      clear_all();
      ext_start_pin = 1'b0;
      step(2);
      check("R2 fall not yet seen", 32'(pending[0]), 32'd0);
      step(1);
      check("R2 falling edge", 32'(pending[0]), 32'(e[1]));
      clear_all();
    end
    c_src[0] = '0; c_rise[0] = 1'b0; c_fall[0] = 1'b0;

    // R3: delay under each divider, bounds from the tick period
    c_src[1] = SW'(4);
    for (int dv = 0; dv < 4; dv++) begin
      for (int d = 1; d <= 3; d += 2) begin
        int p;
        p = (dv == 0) ? 1 : (dv == 1) ? 2 : (dv == 2) ? 4 : 16;
        c_div[1] = 2'(dv); c_dly[1] = DW'(d);
        hw_trig[2] = 1'b1;
        step(1);
        hw_trig[2] = 1'b0;
        step((d - 1) * p);
        check("R3 delay not expired", 32'(pending[1]), 32'd0);
        step(p);
        check("R3 delay expired", 32'(pending[1]), 32'd1);
        clear_all();
      end
    end
    c_div[1] = 2'd3; c_dly[1] = '0;
    hw_trig[2] = 1'b1;
    step(1);
    hw_trig[2] = 1'b0;
    check("R3 zero delay ignores divider", 32'(pending[1]), 32'd1);
    clear_all();

    // R5: cancel stops a running delay
    c_div[1] = 2'd0; c_dly[1] = DW'(5);
    hw_trig[2] = 1'b1;
    step(1);
    hw_trig[2] = 1'b0;
    step(1);
    cancel_vld = 1'b1; cancel_mask = NS'(1) << 1;
    step(1);
    cancel_vld = 1'b0; cancel_mask = '0;
    step(8);
    check("R5 cancelled delay never fires", 32'(pending), 32'd0);
    c_src[1] = '0; c_dly[1] = '0;

    // R4 and R5: mask start and partial cancel
    sw_start(19'h5_0505);
    check("R4 mask start", 32'(pending), 32'h5_0505);
    cancel_vld = 1'b1; cancel_mask = 19'h0_0505;
    step(1);
    cancel_vld = 1'b0; cancel_mask = '0;
    check("R5 partial cancel", 32'(pending), 32'h5_0000);
    check("R5 cancel is not overrun", 32'(ovf_flags), 32'd0);
    clear_all();

    // R6: second start on a pending slot
    sw_start(NS'(1) << 3);
    sw_start(NS'(1) << 3);
    check("R6 overrun flag", 32'(ovf_flags), 32'h8);
    check("R6 ovf_any", 32'(ovf_any), 32'd1);
    check("R6 slot still pending", 32'(pending), 32'h8);
    sw_start_vld = 1'b1; sw_start_mask = NS'(1) << 3;
    ovf_clr_vld = 1'b1; ovf_clr_mask = NS'(1) << 3;
    step(1);
    sw_start_vld = 1'b0; sw_start_mask = '0;
    ovf_clr_vld = 1'b0; ovf_clr_mask = '0;
    check("R6 set wins over clear", 32'(ovf_flags), 32'h8);
    ovf_clr_vld = 1'b1; ovf_clr_mask = NS'(1) << 3;
    step(1);
    ovf_clr_vld = 1'b0; ovf_clr_mask = '0;
    check("R6 clear", 32'(ovf_flags), 32'd0);
    check("R6 ovf_any cleared", 32'(ovf_any), 32'd0);
    clear_all();

    // R6: hardware start while the delay is running
    c_src[2] = SW'(5); c_dly[2] = DW'(4);
    hw_trig[3] = 1'b1;
    step(2);
    hw_trig[3] = 1'b0;
    check("R6 start during delay", 32'(ovf_flags), 32'h4);
    step(4);
    check("R6 first start still served", 32'(pending), 32'h4);
    clear_all();
    c_src[2] = '0; c_dly[2] = '0;

    // R7 and R8: dispatch order with a lower slot arriving mid-conversion
    sw_start((NS'(1) << 2) | (NS'(1) << 5) | (NS'(1) << 9));
    serve(2, 1'b0, 1'b0, '0);
    check("R5 done clears its slot", 32'(pending), 32'h220);
    check("R8 next offer right after done", 32'(conv_vld), 32'd1);
    serve(5, 1'b0, 1'b0, NS'(1) << 1);
    serve(1, 1'b0, 1'b0, '0);
    serve(9, 1'b0, 1'b0, '0);
    check("R7 queue drained", 32'(pending), 32'd0);

    // R9: start in the done cycle of the same slot
    sw_start(NS'(1) << 4);
    serve(4, 1'b1, 1'b0, '0);
    check("R9 stays pending", 32'(pending), 32'h10);
    check("R9 no overrun", 32'(ovf_flags), 32'd0);
    serve(4, 1'b0, 1'b0, '0);
    check("R9 second pass clears", 32'(pending), 32'd0);

    // R10: cancel in flight, restart, done must keep the restart
    sw_start(NS'(1) << 6);
    serve(6, 1'b0, 1'b1, '0);
    check("R10 restart survives done", 32'(pending), 32'h40);
    check("R10 no overrun", 32'(ovf_flags), 32'd0);
    serve(6, 1'b0, 1'b0, '0);
    check("R10 final pending", 32'(pending), 32'd0);
    check("R6 ovf_any at end", 32'(ovf_any), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule